// File: doc/BRIEF.md
# Open-Page DRAM Bank Command Sequencer

This block sits between a request source and one DRAM bank. Each request names a row and a column and says whether it reads or writes. The block keeps the bank's page open after an access, so it always knows whether the bank is precharged or which row sits in the row buffer. It sorts every incoming request into one of three cases and issues only the bank commands that case needs. A request to the open row is a hit and needs a column command alone. A request to a precharged bank is empty and needs an activate, then the column command. A request to any other row is a conflict and needs a precharge, an activate, then the column command.

Requests arrive on a valid/ready handshake, and the block accepts one at a time. Commands leave on a single command port, one per cycle, with idle cycles (NOP) wherever that is needed. Three parameters give the minimum spacing, in cycles, from activate to column command, from precharge to activate, and from activate to precharge. Each command goes out in the first cycle that every spacing allows.

Top module: `dram_page_seq`

## Requirements
- R1: After reset the bank is precharged with no row open, `req_ready` is 1, `cmd_code` is NOP (0) and `req_class` is 0, so the first request is classified empty.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 up to and including the cycle of that request's column command, and returns to 1 in the next cycle.
- R3: `req_class` gives the classification of the request only in its accept cycle: 1 = hit, 2 = empty, 3 = conflict. In every other cycle it is 0.
- R4: A hit produces exactly one command, the column command.
- R5: An empty request produces ACTIVATE, then the column command.
- R6: A conflict produces PRECHARGE, then ACTIVATE, then the column command.
- R7: The command codes are NOP=0, PRECHARGE=1, ACTIVATE=2, READ=3 and WRITE=4. `cmd_row` carries the request's row during ACTIVATE. `cmd_col` carries its column during READ or WRITE. WRITE is used when `req_write` was 1.
- R8: A column command comes at least `T_RCD` cycles after the latest ACTIVATE.
- R9: An ACTIVATE comes at least `T_RP` cycles after the latest PRECHARGE.
- R10: A PRECHARGE comes at least `T_RAS` cycles after the latest ACTIVATE.
- R11: Each command is issued in the earliest cycle that is both after the accept cycle (or after the previous command) and allowed by R8 to R10. Every other cycle carries NOP.
- R12: A row opened by ACTIVATE stays open until a PRECHARGE. PRECHARGE is issued only while a row is open, and ACTIVATE only while none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_class | output | 2 | Classification in the accept cycle (0 elsewhere) |
| cmd_code | output | 3 | Bank command of this cycle |
| cmd_row | output | ROW_W | Row address for ACTIVATE |
| cmd_col | output | COL_W | Column address for READ/WRITE |

## Verification
The bench builds the block with a 2-bit row, a 2-bit column, T_RCD=2, T_RP=3 and T_RAS=5. Each spacing therefore differs from the others and can be told apart. The four-row space lets the bench sweep every ordered pair of rows with 0, 1 and 2 idle cycles between requests. This brings every hit, empty and conflict transition within reach, and it makes the activate-to-precharge spacing either bind or lapse. The bench predicts each command's exact cycle from the three spacings and checks every cycle of every sequence.

// File: rtl/dps_pkg.sv
package dps_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_PRE = 3'd1,
      CMD_ACT = 3'd2,
      CMD_RD  = 3'd3,
      CMD_WR  = 3'd4
   } cmd_e;

   typedef enum logic [1:0] {
      CLS_NONE     = 2'd0,
      CLS_HIT      = 2'd1,
      CLS_EMPTY    = 2'd2,
      CLS_CONFLICT = 2'd3
   } cls_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_NEED_PRE,
      ST_NEED_ACT,
      ST_NEED_COL
   } state_e;
endpackage

// File: rtl/dps_gap_timer.sv
// Saturating age counter: cycles elapsed since the last restart pulse.
module dps_gap_timer #(
   parameter int CNT_MAX = 8,
   localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] age
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         age <= CNT_W'(CNT_MAX);
      else if (restart)
         age <= CNT_W'(1);
      else if (age != CNT_W'(CNT_MAX))
         age <= age + CNT_W'(1);
   end
endmodule

// File: rtl/dps_row_tracker.sv
// Holds the open/closed state of the bank and the open row; classifies a probe row.
module dps_row_tracker #(
   parameter int ROW_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_open,
   input  logic              do_close,
   input  logic [ROW_W-1:0]  open_row_in,
   input  logic [ROW_W-1:0]  probe_row,
   output dps_pkg::cls_e     probe_cls
);
   logic             is_open_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open_q <= 1'b0;
         row_q     <= '0;
      end else if (do_open) begin
         is_open_q <= 1'b1;
         row_q     <= open_row_in;
      end else if (do_close) begin
         is_open_q <= 1'b0;
      end
   end

   always_comb begin
      if (!is_open_q)
         probe_cls = dps_pkg::CLS_EMPTY;
      else if (row_q == probe_row)
         probe_cls = dps_pkg::CLS_HIT;
      else
         probe_cls = dps_pkg::CLS_CONFLICT;
   end
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
   parameter int ROW_W = 14,
   parameter int COL_W = 10,
   parameter int T_RCD = 4,
   parameter int T_RP  = 4,
   parameter int T_RAS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   output logic [1:0]       req_class,
   output logic [2:0]       cmd_code,
   output logic [ROW_W-1:0] cmd_row,
   output logic [COL_W-1:0] cmd_col
);
   import dps_pkg::*;

   localparam int GAP_MAX = (T_RAS > T_RCD) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                            : ((T_RCD > T_RP) ? T_RCD : T_RP);
   localparam int CNT_W   = $clog2(GAP_MAX + 1);
   localparam int N_TMR   = 2;   // index 0: since ACTIVATE, index 1: since PRECHARGE

   if (ROW_W < 1 || COL_W < 1) begin : g_bad_width
      $error("dram_page_seq: address widths must be at least 1");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RAS < 1) begin : g_bad_gap
      $error("dram_page_seq: every minimum gap must be at least 1 cycle");
   end

   state_e           state_q, state_d;
   logic             wr_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             accept, do_act, do_pre;
   cls_e             cls;
   cmd_e             cmd;
   logic [N_TMR-1:0] tmr_restart;
   logic [CNT_W-1:0] tmr_age [N_TMR];

   assign tmr_restart = {do_pre, do_act};

   for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
      dps_gap_timer #(.CNT_MAX(GAP_MAX)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (tmr_restart[g]),
         .age     (tmr_age[g])
      );
   end

   logic rcd_ok, ras_ok, rp_ok;
   assign rcd_ok = tmr_age[0] >= CNT_W'(T_RCD);
   assign ras_ok = tmr_age[0] >= CNT_W'(T_RAS);
   assign rp_ok  = tmr_age[1] >= CNT_W'(T_RP);

   dps_row_tracker #(.ROW_W(ROW_W)) u_rows (
      .clk         (clk),
      .rst_n       (rst_n),
      .do_open     (do_act),
      .do_close    (do_pre),
      .open_row_in (row_q),
      .probe_row   (req_row),
      .probe_cls   (cls)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign req_class = accept ? cls : CLS_NONE;

   always_comb begin
      state_d = state_q;
      cmd     = CMD_NOP;
      do_act  = 1'b0;
      do_pre  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               unique case (cls)
                  CLS_HIT:   state_d = ST_NEED_COL;
                  CLS_EMPTY: state_d = ST_NEED_ACT;
                  default:   state_d = ST_NEED_PRE;
               endcase
            end
         end
         ST_NEED_PRE: begin
            if (ras_ok) begin
               cmd     = CMD_PRE;
               do_pre  = 1'b1;
               state_d = ST_NEED_ACT;
            end
         end
         ST_NEED_ACT: begin
            if (rp_ok) begin
               cmd     = CMD_ACT;
               do_act  = 1'b1;
               state_d = ST_NEED_COL;
            end
         end
         default: begin
            if (rcd_ok) begin
               cmd     = wr_q ? CMD_WR : CMD_RD;
               state_d = ST_IDLE;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         row_q   <= '0;
         col_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            wr_q  <= req_write;
            row_q <= req_row;
            col_q <= req_col;
         end
      end
   end

   assign cmd_code = cmd;
   assign cmd_row  = row_q;
   assign cmd_col  = col_q;
endmodule

// File: rtl/dram_page_seq_chk.sv
module dram_page_seq_chk #(
   parameter int ROW_W = 14,
   parameter int COL_W = 10,
   parameter int T_RCD = 4,
   parameter int T_RP  = 4,
   parameter int T_RAS = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [1:0]       req_class,
   input logic [2:0]       cmd_code,
   input logic [ROW_W-1:0] cmd_row,
   input logic [COL_W-1:0] cmd_col
);
   localparam int LIM = T_RAS + T_RCD + T_RP;
   localparam int CW  = $clog2(LIM + 1);

   logic [CW-1:0] since_act, since_pre;
   logic          open_seen;
   logic          is_col, is_act, is_pre;

   assign is_col = (cmd_code == 3'd3) || (cmd_code == 3'd4);
   assign is_act = (cmd_code == 3'd2);
   assign is_pre = (cmd_code == 3'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= CW'(LIM);
         since_pre <= CW'(LIM);
         open_seen <= 1'b0;
      end else begin
         since_act <= is_act ? CW'(1) : ((since_act == CW'(LIM)) ? since_act : since_act + CW'(1));
         since_pre <= is_pre ? CW'(1) : ((since_pre == CW'(LIM)) ? since_pre : since_pre + CW'(1));
         if (is_act) open_seen <= 1'b1;
         else if (is_pre) open_seen <= 1'b0;
      end
   end

   p_class_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_class != 2'd0) |-> (req_valid && req_ready));
   p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   p_col_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> (since_act >= CW'(T_RCD)));
   p_act_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> (since_pre >= CW'(T_RP)));
   p_pre_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> (since_act >= CW'(T_RAS)));
   p_pre_when_open_r12: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> open_seen);
   p_act_when_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> !open_seen);
   p_col_when_open_r12: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> open_seen);
   p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_code <= 3'd4);
   p_nop_while_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cmd_code == 3'd0));
endmodule

bind dram_page_seq dram_page_seq_chk #(
   .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_class (req_class),
   .cmd_code  (cmd_code),
   .cmd_row   (cmd_row),
   .cmd_col   (cmd_col)
);

// File: tb/dram_page_seq_tb.sv
module dram_page_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ROW_W = 2;
   localparam int COL_W = 2;
   localparam int T_RCD = 2;
   localparam int T_RP  = 3;
   localparam int T_RAS = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic             req_write = 1'b0;
   logic [ROW_W-1:0] req_row = '0;
   logic [COL_W-1:0] req_col = '0;
   logic [1:0]       req_class;
   logic [2:0]       cmd_code;
   logic [ROW_W-1:0] cmd_row;
   logic [COL_W-1:0] cmd_col;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // model state
   bit m_open = 0;
   int m_row = 0;
   int last_act = -1000;
   int last_pre = -1000;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dram_page_seq #(
      .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_row(req_row), .req_col(req_col),
      .req_class(req_class), .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col)
   );

   task automatic check(input bit ok, input string tag, input int got, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, got, exp);
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic run_req(input bit wr, input int row, input int col, input int gap);
      int ecode[3];
      int ecyc[3];
      int n;
      int exp_cls;
      int acc;
      int t0;
      string ctag;
      repeat (gap) begin
         @(negedge clk);
         check(req_ready == 1'b1, "R2 idle ready", int'(req_ready), 1);
         check(cmd_code == 3'd0, "R11 idle nop", int'(cmd_code), 0);
      end
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_row   = ROW_W'(row);
      req_col   = COL_W'(col);
      #1;
      acc = cyc;
      exp_cls = !m_open ? 2 : ((m_row == row) ? 1 : 3);
      ctag = (exp_cls == 1) ? "R4" : ((exp_cls == 2) ? "R5" : "R6");
      check(req_ready == 1'b1, "R2 ready at accept", int'(req_ready), 1);
      check(int'(req_class) == exp_cls, "R3 R12 class", int'(req_class), exp_cls);
      n = 0;
      t0 = acc + 1;
      if (exp_cls == 3) begin
         ecode[0] = 1; ecyc[0] = imax(t0, last_act + T_RAS);
         ecode[1] = 2; ecyc[1] = ecyc[0] + T_RP;
         ecode[2] = wr ? 4 : 3; ecyc[2] = ecyc[1] + T_RCD;
         n = 3;
         last_pre = ecyc[0];
         last_act = ecyc[1];
      end else if (exp_cls == 2) begin
         ecode[0] = 2; ecyc[0] = imax(t0, last_pre + T_RP);
         ecode[1] = wr ? 4 : 3; ecyc[1] = ecyc[0] + T_RCD;
         n = 2;
         last_act = ecyc[0];
      end else begin
         ecode[0] = wr ? 4 : 3; ecyc[0] = imax(t0, last_act + T_RCD);
         n = 1;
      end
      m_open = 1;
      m_row = row;
      for (int t = t0; t <= ecyc[n-1]; t++) begin
         int exp_code;
         string gtag;
         @(negedge clk);
         req_valid = 1'b0;
         exp_code = 0;
         for (int k = 0; k < n; k++) if (ecyc[k] == t) exp_code = ecode[k];
         gtag = (exp_code == 1) ? "R10" : ((exp_code == 2) ? "R9" :
                ((exp_code == 0) ? "R11" : "R8"));
         check(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
         check(req_class == 2'd0, "R3 class idle", int'(req_class), 0);
         check(int'(cmd_code) == exp_code, {ctag, " ", gtag, " command"}, int'(cmd_code), exp_code);
         if (exp_code == 2)
            check(int'(cmd_row) == row, "R7 act row", int'(cmd_row), row);
         if (exp_code == 3 || exp_code == 4)
            check(int'(cmd_col) == col, "R7 column", int'(cmd_col), col);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      check(cmd_code == 3'd0, "R1 nop after reset", int'(cmd_code), 0);
      check(req_class == 2'd0, "R1 no class after reset", int'(req_class), 0);
      // first request after reset must be empty (checked inside as class 2)
      run_req(1'b0, 2, 1, 0);
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int g = 0; g < 3; g++) begin
               run_req(((a + g) % 2) == 1, a, (a + b) % 4, g);
               run_req(((b + g) % 2) == 0, b, (b + g) % 4, g);
            end
      // repeated hits with no gap, then a conflict right after a fresh activate
      run_req(1'b1, 1, 3, 0);
      run_req(1'b0, 1, 0, 0);
      run_req(1'b1, 1, 2, 0);
      run_req(1'b0, 3, 1, 0);
      run_req(1'b1, 0, 2, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired at cycle %0d: actual=%0d expected=%0d", cyc, 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule